// File: doc/BRIEF.md
# PHY Register Handshake Access Sequencer

This block gives a host access to 16-bit registers held inside a PHY that has no memory-mapped port. The only path into the PHY is a 20-bit control word driven by the block and a 17-bit status word sampled from the PHY. The block turns a single host request into a series of handshake phases over that path. The request is either a read or a write and carries a PHY address and write data. Each phase raises a strobe in the control word. It then waits for the PHY acknowledge to go high, drops the strobe and waits for the acknowledge to go low again.

The host presents a request while `busy` is low. When the operation completes, the block answers with a one-cycle `done` pulse. If an acknowledge never arrives, it answers with a one-cycle `err` pulse instead. For reads, the returned data is held on `rd_data`. Every acknowledge wait is bounded: the block samples the acknowledge a fixed number of times, spaced a fixed number of clock cycles apart, and gives up when the expected level has not appeared.

Top module: `phy_hs_seq`

## Requirements
- R1: The control word carries the address or data value in bits [15:0]. Bit 16 captures the address, bit 17 captures data, bit 18 is the write strobe and bit 19 is the read strobe. At most one of bits [19:16] is set at any time.
- R2: The status word carries PHY read data in bits [15:0] and the acknowledge in bit 16.
- R3: Every access begins with an address phase, in this order. The block drives the address with no strobe, then the address with bit 16 set, and waits for ack high. It then drives the address with no strobe again and waits for ack low.
- R4: After the address phase, a read drives only bit 19 and waits for ack high. On that successful sample it latches status bits [15:0] into `rd_data`. It then drives the control word to zero and waits for ack low, and `done` follows. `rd_data` stays unchanged while the block is idle.
- R5: After the address phase, a write drives the data with no strobe, then the data with bit 17 set, and waits for ack high. It then drives the data with no strobe and waits for ack low.
- R6: The write then drives only bit 18 and waits for ack high. It drives the data with no strobe, waits for ack low and finally drives the control word to zero, and `done` follows.
- R7: Each acknowledge wait samples at most POLL_MAX times (default 10), with GAP clock cycles between samples (default 250, one microsecond at 250 MHz). The first sample comes one cycle after the strobe is driven. If the acknowledge stays low in the first wait, `err` rises 3 + (POLL_MAX-1)*GAP cycles after the accepting clock edge. If it stays high through the first low wait, `err` rises 5 + (POLL_MAX-1)*GAP cycles after that edge.
- R8: On timeout, the control word returns to zero, `busy` falls and no `done` is raised for that operation.
- R9: A request is accepted only while `busy` is low. A request presented while busy has no effect on the control word or on PHY contents.
- R10: `done` and `err` are single-cycle pulses. Exactly one of them is raised per operation, and never both in the same cycle.
- R11: After reset, `busy`, `done`, `err` and the control word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, honoured when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Operation in progress |
| rd_data | output | 16 | Data from the last completed read |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle timeout pulse |
| phy_ctrl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Status word from the PHY |

## Verification
The bench sweeps the responder's acknowledge latency, from immediate to late within the poll window. A design that sampled too few times, or spaced its samples wrongly, would time out on the late cases. The bench compares the exact sequence of control-word changes for both reads and writes, so a strobe out of order, a missing "value alone" step or a missing final zero shows up as a trace mismatch. It times out the acknowledge stuck low and stuck high, and checks the exact cycle of `err`, so an off-by-one poll count is caught. It also injects a request mid-operation and reads the untouched register back, which exposes a design that accepted it.

// File: rtl/phy_hs_seq.sv
module phy_hs_seq #(
  parameter int DW       = 16,
  parameter int POLL_MAX = 10,
  parameter int GAP      = 250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          err,
  output logic [DW+3:0] phy_ctrl,
  input  logic [DW:0]   phy_stat
);
  localparam int CW     = DW + 4;
  localparam int CAPA   = DW;
  localparam int CAPD   = DW + 1;
  localparam int WRB    = DW + 2;
  localparam int RDB    = DW + 3;
  localparam int PW     = $clog2(POLL_MAX + 1);
  localparam int GW     = $clog2(GAP + 1);

  logic          active, wr;
  logic [3:0]    step;
  logic [DW-1:0] addr_q, data_q;
  logic [PW-1:0] polls;
  logic [GW-1:0] gap;

  logic          is_wait, lvl, last;
  logic [CW-1:0] val;

  wire           ack     = phy_stat[DW];
  wire [CW-1:0]  a_word  = {4'b0, addr_q};
  wire [CW-1:0]  d_word  = {4'b0, data_q};

  assign busy = active;

  always_comb begin
    is_wait = 1'b0;
    lvl     = 1'b0;
    last    = 1'b0;
    val     = '0;
    case (step)
      4'd0: val = a_word;
      4'd1: val = a_word | (CW'(1) << CAPA);
      4'd2: begin is_wait = 1'b1; lvl = 1'b1; end
      4'd3: val = a_word;
      4'd4: is_wait = 1'b1;
      4'd5: val = wr ? d_word : (CW'(1) << RDB);
      4'd6: if (wr) val = d_word | (CW'(1) << CAPD);
            else begin is_wait = 1'b1; lvl = 1'b1; end
      4'd7: if (wr) begin is_wait = 1'b1; lvl = 1'b1; end
            else val = '0;
      4'd8: if (wr) val = d_word;
            else begin is_wait = 1'b1; last = 1'b1; end
      4'd9:  is_wait = 1'b1;
      4'd10: val = CW'(1) << WRB;
      4'd11: begin is_wait = 1'b1; lvl = 1'b1; end
      4'd12: val = d_word;
      4'd13: is_wait = 1'b1;
      default: begin val = '0; last = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      wr       <= 1'b0;
      step     <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      polls    <= '0;
      gap      <= '0;
      rd_data  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      phy_ctrl <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!active) begin
        if (req_valid) begin
          active <= 1'b1;
          wr     <= req_write;
          addr_q <= req_addr;
          data_q <= req_wdata;
          step   <= '0;
          polls  <= '0;
          gap    <= '0;
        end
      end else if (!is_wait) begin
        phy_ctrl <= val;
        if (last) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          step <= step + 4'd1;
        end
      end else if (gap != '0) begin
        gap <= gap - GW'(1);
      end else if (ack == lvl) begin
        polls <= '0;
        if (!wr && step == 4'd6) rd_data <= phy_stat[DW-1:0];
        if (last) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          step <= step + 4'd1;
        end
      end else if (polls == PW'(POLL_MAX - 1)) begin
        active   <= 1'b0;
        err      <= 1'b1;
        phy_ctrl <= '0;
        polls    <= '0;
      end else begin
        polls <= polls + PW'(1);
        gap   <= GW'(GAP - 1);
      end
    end
  end

  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phy_ctrl[RDB:CAPA]));

  // R10
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |=> !(done || err));

  // R8
  idle_ctrl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> phy_ctrl == '0);

  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rd_data));

  // R8
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
endmodule

// File: tb/phy_hs_seq_tb.sv
module phy_hs_seq_tb;
  localparam int G  = 3;
  localparam int PM = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        busy, done, err;
  logic [15:0] rd_data;
  logic [19:0] phy_ctrl;
  logic [16:0] phy_stat;

  always #2 clk = ~clk;

  phy_hs_seq #(.DW(16), .POLL_MAX(PM), .GAP(G)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .rd_data(rd_data),
    .done(done), .err(err), .phy_ctrl(phy_ctrl), .phy_stat(phy_stat));

  // PHY responder
  int          mode = 0;
  int          lat  = 0;
  logic [63:0] sh = '0;
  logic [15:0] pmem [16];
  logic [15:0] cap_a = '0, cap_d = '0;
  logic        wr_prev = 1'b0;
  logic        ack;

  initial for (int i = 0; i < 16; i++) pmem[i] = 16'hA500 + 16'(i * 16'h0111);

  always @(posedge clk) begin
    sh <= {sh[62:0], |phy_ctrl[19:16]};
    if (phy_ctrl[16]) cap_a <= phy_ctrl[15:0];
    if (phy_ctrl[17]) cap_d <= phy_ctrl[15:0];
    wr_prev <= phy_ctrl[18];
    if (phy_ctrl[18] && !wr_prev) pmem[cap_a[3:0]] <= cap_d;
  end

  always_comb begin
    if (mode == 1)      ack = 1'b0;
    else if (mode == 2) ack = 1'b1;
    else if (lat == 0)  ack = |phy_ctrl[19:16];
    else                ack = sh[lat-1];
  end
  assign phy_stat = {ack, pmem[cap_a[3:0]]};

  // control trace
  logic [19:0] trace [32];
  int          trace_n = 0;
  logic [19:0] last_ctrl = '0;
  always @(negedge clk) begin
    if (phy_ctrl !== last_ctrl) begin
      if (trace_n < 32) trace[trace_n] = phy_ctrl;
      trace_n++;
      last_ctrl = phy_ctrl;
    end
  end

  logic [19:0] expv [32];
  int          exp_n;
  logic [19:0] exp_last;
  task automatic epush(input logic [19:0] v);
    if (v != exp_last) begin expv[exp_n] = v; exp_n++; exp_last = v; end
  endtask

  task automatic build_exp(input bit wr, input logic [15:0] a, input logic [15:0] d);
    exp_n = 0; exp_last = '0;
    epush({4'b0, a}); epush({4'b0001, a}); epush({4'b0, a});
    if (wr) begin
      epush({4'b0, d}); epush({4'b0010, d}); epush({4'b0, d});
      epush({4'b0100, 16'h0}); epush({4'b0, d}); epush(20'h0);
    end else begin
      epush({4'b1000, 16'h0}); epush(20'h0);
    end
  endtask

  int checks = 0, fails = 0;
  logic [15:0] emem [16];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input bit intrude, output int nd, output int ne, output int cyc);
    trace_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    cyc = 0; nd = 0; ne = 0;
    @(negedge clk);
    req_valid = 1'b0;
    while (cyc < 1000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (intrude && cyc == 4) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 16'h0005; req_wdata = 16'h1234;
      end else req_valid = 1'b0;
      if (done) nd++;
      if (err) ne++;
      if (done || err) break;
    end
    req_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done) nd++;
      if (err) ne++;
    end
  endtask

  task automatic check_trace(input string req);
    bit ok = (trace_n == exp_n);
    for (int i = 0; i < 32; i++)
      if (ok && i < exp_n && trace[i] != expv[i]) ok = 0;
    check(ok, req, "control trace", longint'(trace_n), longint'(exp_n));
  endtask

  int wd = 0;
  initial begin
    forever begin
      @(posedge clk); wd++;
      if (wd > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 100000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    int nd, ne, cyc;
    int lats [7] = '{0, 1, 2, 3, 5, 8, 20};
    for (int i = 0; i < 16; i++) emem[i] = 16'hA500 + 16'(i * 16'h0111);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11
    check(busy == 0 && done == 0 && err == 0 && phy_ctrl == 0, "R11", "reset state",
          longint'({busy, done, err, phy_ctrl}), 0);
    rst_n = 1'b1;

    // read of untouched register: R2 R3 R4
    mode = 0; lat = 0;
    run_op(0, 16'h0103, 16'h0, 0, nd, ne, cyc);
    build_exp(0, 16'h0103, 16'h0);
    check_trace("R3");
    check(rd_data == emem[3], "R2", "read data", rd_data, emem[3]);
    check(nd == 1 && ne == 0, "R10", "one done per read", nd, 1);

    // latency sweep, write then read back: R1 R4 R5 R6 R7
    for (int li = 0; li < 7; li++) begin
      logic [15:0] a = 16'h0200 + 16'(li + 8);
      logic [15:0] d = 16'h5A00 ^ 16'(li * 16'h1357);
      lat = lats[li];
      run_op(1, a, d, 0, nd, ne, cyc);
      emem[a[3:0]] = d;
      build_exp(1, a, d);
      check_trace("R5");
      check(nd == 1 && ne == 0, "R6", "write done", nd, 1);
      run_op(0, a, 16'h0, 0, nd, ne, cyc);
      build_exp(0, a, 16'h0);
      check_trace("R1");
      check(rd_data == emem[a[3:0]], "R4", "read back", rd_data, emem[a[3:0]]);
      check(nd == 1 && ne == 0, "R7", "late ack accepted", ne, 0);
    end

    // request while busy ignored: R9
    lat = 2;
    run_op(1, 16'h0301, 16'hBEEF, 1, nd, ne, cyc);
    emem[1] = 16'hBEEF;
    build_exp(1, 16'h0301, 16'hBEEF);
    check_trace("R9");
    run_op(0, 16'h0304, 16'h0, 0, nd, ne, cyc);
    check(rd_data == emem[4], "R9", "untouched register", rd_data, emem[4]);

    // ack stuck low: R7 R8
    mode = 1;
    run_op(0, 16'h0007, 16'h0, 0, nd, ne, cyc);
    check(cyc == 3 + (PM - 1) * G, "R7", "timeout cycle stuck low", cyc, 3 + (PM - 1) * G);
    check(ne == 1 && nd == 0, "R8", "err without done", nd, 0);
    check(phy_ctrl == 0 && busy == 0, "R8", "ctrl zero after timeout", phy_ctrl, 0);

    // ack stuck high
    mode = 2;
    run_op(1, 16'h0009, 16'h1111, 0, nd, ne, cyc);
    check(cyc == 5 + (PM - 1) * G, "R7", "timeout cycle stuck high", cyc, 5 + (PM - 1) * G);
    check(ne == 1 && nd == 0, "R10", "single err pulse", ne, 1);

    // ack later than the poll window
    mode = 0; lat = 30;
    run_op(0, 16'h000A, 16'h0, 0, nd, ne, cyc);
    check(ne == 1 && nd == 0, "R7", "ack beyond window", ne, 1);
    check(phy_ctrl == 0 && busy == 0, "R8", "idle after timeout", busy, 0);

    // recovery after timeout
    lat = 1;
    repeat (40) @(posedge clk);
    run_op(0, 16'h000B, 16'h0, 0, nd, ne, cyc);
    check(nd == 1 && rd_data == emem[11], "R4", "read after timeout", rd_data, emem[11]);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule